// File: doc/BRIEF.md
# Eight-Channel External Interrupt Detector

This block watches eight asynchronous input pins and turns activity on them into latched request flags. Each pin first passes through a two-flop synchroniser. A 2-bit mode per pin then selects what counts as a request: a low level, a high level, a rising edge or a falling edge. A detected event sets that pin's sticky flag. Software reads the flags and clears chosen bits by writing zeros to them. An enable mask picks which flags drive the single registered interrupt output.

The register bus is synchronous. It has a select, a write strobe, a two-bit word address, two byte enables, 16-bit write data, combinational read data, and a qualifier that marks the read phase of a read-modify-write. During that phase the flag word reads as all ones. The write-back can then clear only the bits software deliberately wrote as zero, and a request that arrives between the read and the write is not lost. In a level mode a cleared flag comes straight back while the pin stays at its active level.

Top module: `ext_irq_detect`

## Requirements
- R1: While reset is asserted, and after it is released, the flag word (address 0, bits 7:0), the enable word (address 1, bits 7:0) and the mode word (address 2, bits 15:0) read as zero, and irq_o is 0.
- R2: A flag bit is set by a detected event on its pin and then stays set until software clears it. Without an event and without a clear it never changes.
- R3: A write to address 0 with byte enable 0 set clears every flag bit whose write-data bit is 0. A data bit of 1 leaves its flag unchanged. The write has no effect at all when byte enable 0 is clear.
- R4: When bus_rmw is 1, a read of address 0 returns 1 in all eight flag bits, whatever the flags hold.
- R5: Pin i takes its mode from bits [2i+1:2i] of the mode word. Encoding: 00 is low level, 01 is high level, 10 is rising edge, 11 is falling edge. Byte enable 0 writes bits 7:0 of the mode word and byte enable 1 writes bits 15:8.
- R6: In a level mode, a flag that is cleared while its pin is still at the active level reads 1 again.
- R7: An edge is found by comparing the synchronised pin with its value one cycle earlier. A pin change reaches its flag at the third rising clock edge after it.
- R8: irq_o is a register that holds the OR, over all channels, of flag AND enable. Flags still record events while their enable bit is 0.
- R9: If a detected event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: Changing a pin's mode leaves its flag as it was. Changing a mode while the pin is steady produces no edge event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_rmw | input | 1 | Marks the read phase of a read-modify-write |
| bus_addr | input | 2 | Word address: 0 flags, 1 enables, 2 modes |
| bus_be | input | 2 | Byte enables for the write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pin_i | input | 8 | Asynchronous request pins |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
A hardware set and a software clear of the same flag can fall in the same clock cycle. The bench provokes this in rising-edge mode by timing a write of zero so that it is sampled at exactly the edge where the synchronised rise is detected. It then expects the flag to read 1. A second case holds a pin at its active level while software clears the flag, and the flag must still read 1. A follow-up clear made after the pin has settled must then bring the flag to 0, which shows the clear path works apart from the collision.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    typedef enum logic [1:0] {
        DET_LOW  = 2'b00,
        DET_HIGH = 2'b01,
        DET_RISE = 2'b10,
        DET_FALL = 2'b11
    } det_mode_e;

    localparam int          ADDR_W   = 2;
    localparam int          DATA_W   = 16;
    localparam logic [1:0]  ADR_FLAG = 2'd0;
    localparam logic [1:0]  ADR_EN   = 2'd1;
    localparam logic [1:0]  ADR_MODE = 2'd2;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < STAGES; s++) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_d[s];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
    import eirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_s,
    input  det_mode_e mode,
    input  logic      clr,
    output logic      flag_o
);

    typedef struct packed {
        logic prev;
        logic flag;
    } chan_t;

    chan_t cur_q, nxt_d;
    logic  hit;

    always_comb begin
        unique case (mode)
            DET_LOW:  hit = ~pin_s;
            DET_HIGH: hit = pin_s;
            DET_RISE: hit = pin_s & ~cur_q.prev;
            DET_FALL: hit = ~pin_s & cur_q.prev;
            default:  hit = 1'b0;
        endcase
        nxt_d.prev = pin_s;
        nxt_d.flag = hit | (cur_q.flag & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign flag_o = cur_q.flag;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_o);                                   // R9
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !flag_o);                        // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr) |=> flag_o);                      // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !hit) |=> !flag_o);                    // R2
    AST_LEVEL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DET_HIGH && pin_s) |=> flag_o);           // R6

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import eirq_pkg::*;
#(
    parameter int N_CH        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_rmw,
    input  logic [1:0]  bus_addr,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic [7:0]  pin_i,
    output logic        irq_o
);

    localparam int MODE_W = 2 * N_CH;

    typedef struct packed {
        logic [N_CH-1:0]   en;
        logic [MODE_W-1:0] mode;
        logic              irq;
    } regs_t;

    regs_t           regs_q, regs_d;
    logic [N_CH-1:0] pin_s;
    logic [N_CH-1:0] flags;
    logic [N_CH-1:0] clr_vec;
    logic            wr_en;
    logic [15:0]     rdata_c;

    eirq_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_i[N_CH-1:0]),
        .dout  (pin_s)
    );

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_ch
            eirq_chan u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin_s  (pin_s[g]),
                .mode   (det_mode_e'(regs_q.mode[2*g +: 2])),
                .clr    (clr_vec[g]),
                .flag_o (flags[g])
            );
        end
    endgenerate

    always_comb begin
        wr_en   = bus_sel & bus_wr;
        clr_vec = '0;
        if (wr_en && bus_addr == ADR_FLAG && bus_be[0]) begin
            clr_vec = ~bus_wdata[N_CH-1:0];
        end

        regs_d = regs_q;
        if (wr_en && bus_addr == ADR_EN && bus_be[0]) begin
            regs_d.en = bus_wdata[N_CH-1:0];
        end
        if (wr_en && bus_addr == ADR_MODE) begin
            for (int b = 0; b < MODE_W; b++) begin
                if (bus_be[b/8]) regs_d.mode[b] = bus_wdata[b];
            end
        end
        regs_d.irq = |(flags & regs_q.en);

        rdata_c = '0;
        unique case (bus_addr)
            ADR_FLAG: rdata_c[N_CH-1:0]   = bus_rmw ? {N_CH{1'b1}} : flags;
            ADR_EN:   rdata_c[N_CH-1:0]   = regs_q.en;
            ADR_MODE: rdata_c[MODE_W-1:0] = regs_q.mode;
            default:  rdata_c             = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bus_rdata = rdata_c;
    assign irq_o     = regs_q.irq;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & regs_q.en) == '0) |=> !irq_o);           // R8
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & regs_q.en) != '0) |=> irq_o);            // R8
    AST_RMW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rmw && bus_addr == ADR_FLAG) |-> (bus_rdata[N_CH-1:0] == {N_CH{1'b1}})); // R4
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bus_addr == ADR_EN) |=> $stable(regs_q.en)); // R1

endmodule

// File: tb/sim_ext_irq_detect.sv
module sim_ext_irq_detect;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rmw = 1'b0;
    logic [1:0]  bus_addr = 2'd0, bus_be = 2'b00;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [7:0]  pin = 8'h00;
    logic        irq_o;

    int n_run = 0, n_fail = 0;
    logic [15:0] rv;

    always #2 clk = ~clk;

    ext_irq_detect u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rmw(bus_rmw), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin), .irq_o(irq_o)
    );

    // table entry: {channel[2:0], mode[1:0], pin_before, pin_after, expected_flag}
    localparam logic [7:0] VEC [8] = '{
        {3'd0, 2'b00, 1'b1, 1'b0, 1'b1},
        {3'd1, 2'b00, 1'b1, 1'b1, 1'b0},
        {3'd2, 2'b01, 1'b0, 1'b1, 1'b1},
        {3'd3, 2'b01, 1'b1, 1'b0, 1'b1},
        {3'd4, 2'b10, 1'b0, 1'b1, 1'b1},
        {3'd5, 2'b10, 1'b1, 1'b0, 1'b0},
        {3'd6, 2'b11, 1'b1, 1'b0, 1'b1},
        {3'd7, 2'b11, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 2'b00;
    endtask

    task automatic rd(input logic [1:0] a, input logic rmw, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = a; bus_rmw = rmw;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rmw = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // reset state, sampled while reset is held (R1)
        cyc(3);
        rd(2'd0, 1'b0, rv); check("R1 flags in reset", rv, 16'h0);
        rd(2'd1, 1'b0, rv); check("R1 enables in reset", rv, 16'h0);
        rd(2'd2, 1'b0, rv); check("R1 modes in reset", rv, 16'h0);
        check("R1 irq in reset", {15'h0, irq_o}, 16'h0);
        pin = 8'hFF;
        cyc(4);
        rst_n = 1'b1;
        rd(2'd1, 1'b0, rv); check("R1 enables after reset", rv, 16'h0);

        // table walk (R2, R5, R6, R7)
        for (int i = 0; i < 8; i++) begin
            logic [2:0] ch;
            logic [1:0] md;
            ch = VEC[i][7:5];
            md = VEC[i][4:3];
            pin[ch] = VEC[i][2];
            wr(2'd2, 2'b11, 16'(md) << (2 * ch));
            cyc(6);
            wr(2'd0, 2'b01, 16'h0000);
            cyc(2);
            pin[ch] = VEC[i][1];
            cyc(6);
            rd(2'd0, 1'b0, rv);
            check($sformatf("R5 R6 R2 table entry %0d", i), {15'h0, rv[ch]}, {15'h0, VEC[i][0]});
        end

        // exact latency of an edge: third rising edge after the pin change (R7)
        wr(2'd2, 2'b11, 16'h0002);      // ch0 rising
        pin[0] = 1'b0;
        cyc(4);
        wr(2'd0, 2'b01, 16'h0000);
        cyc(2);
        @(negedge clk); pin[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        #1 check("R7 flag not yet after two edges", {15'h0, bus_rdata[0]}, 16'h0);
        @(negedge clk);
        bus_addr = 2'd0;
        #1 check("R7 flag after three edges", {15'h0, bus_rdata[0]}, 16'h1);

        // write semantics: mode all high-level, pins all low -> no events (R3)
        pin = 8'h00;
        wr(2'd2, 2'b11, 16'h5555);
        cyc(4);
        wr(2'd0, 2'b01, 16'h0000);
        cyc(3);
        rd(2'd0, 1'b0, rv); check("R3 write zero clears", rv, 16'h0);
        pin[2] = 1'b1; cyc(5); pin[2] = 1'b0; cyc(4);
        rd(2'd0, 1'b0, rv); check("R2 flag sticky after pulse", rv, 16'h0004);
        wr(2'd0, 2'b01, 16'h00FF);
        rd(2'd0, 1'b0, rv); check("R3 write one no effect", rv, 16'h0004);
        wr(2'd0, 2'b00, 16'h0000);
        rd(2'd0, 1'b0, rv); check("R3 disabled byte lane no effect", rv, 16'h0004);
        rd(2'd0, 1'b1, rv); check("R4 rmw reads ones", rv, 16'h00FF);

        // enable gating (R8)
        cyc(3);
        check("R8 irq low while disabled", {15'h0, irq_o}, 16'h0);
        wr(2'd1, 2'b01, 16'h0004);
        cyc(3);
        check("R8 irq high when enabled", {15'h0, irq_o}, 16'h1);
        wr(2'd1, 2'b01, 16'h0008);
        cyc(3);
        check("R8 irq low with other enable", {15'h0, irq_o}, 16'h0);
        wr(2'd1, 2'b01, 16'h0000);

        // set and clear in the same cycle, rising mode on ch4 (R9)
        wr(2'd2, 2'b11, 16'h0200);
        pin[4] = 1'b0;
        cyc(4);
        wr(2'd0, 2'b01, 16'h0000);
        @(negedge clk); pin[4] = 1'b1;   // next edge P1
        @(negedge clk);                  // after P1
        @(negedge clk);                  // after P2, hit valid until P3
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_be = 2'b01; bus_wdata = 16'h0000;
        @(negedge clk);                  // after P3
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 2'b00;
        rd(2'd0, 1'b0, rv); check("R9 set wins over clear", {15'h0, rv[4]}, 16'h1);
        wr(2'd0, 2'b01, 16'h0000);
        rd(2'd0, 1'b0, rv); check("R9 later clear takes", {15'h0, rv[4]}, 16'h0);

        // level re-set while active (R6)
        wr(2'd2, 2'b11, 16'h0000);       // all low-level, pin[0..3] low except ch4
        cyc(4);
        wr(2'd0, 2'b01, 16'h0000);
        rd(2'd0, 1'b0, rv); check("R6 level flag returns", {15'h0, rv[0]}, 16'h1);

        // mode change keeps flag, steady pin gives no edge (R10)
        pin = 8'hFF;
        wr(2'd2, 2'b11, 16'h0004);       // ch1 high level
        cyc(4);
        wr(2'd2, 2'b11, 16'h0008);       // ch1 rising
        rd(2'd0, 1'b0, rv); check("R10 mode change keeps flag", {15'h0, rv[1]}, 16'h1);
        wr(2'd0, 2'b01, 16'h0000);
        cyc(4);
        rd(2'd0, 1'b0, rv); check("R10 no spurious rise", {15'h0, rv[1]}, 16'h0);
        wr(2'd2, 2'b11, 16'h000C);       // ch1 falling
        cyc(4);
        rd(2'd0, 1'b0, rv); check("R10 no spurious fall", {15'h0, rv[1]}, 16'h0);

        // byte enables on the mode word (R5)
        wr(2'd2, 2'b11, 16'h0000);
        wr(2'd2, 2'b01, 16'h1234);
        rd(2'd2, 1'b0, rv); check("R5 low lane only", rv, 16'h0034);
        wr(2'd2, 2'b10, 16'hABCD);
        rd(2'd2, 1'b0, rv); check("R5 high lane only", rv, 16'hAB34);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule